// File: doc/BRIEF.md
# VID Reference Slew and Soft-Start Sequencer

This block turns an 8-bit voltage-identification (VID) code into the level that feeds a reference DAC. It stands between the VID pins and the DAC. It never jumps the reference. An up/down level counter moves one 6.25 mV step per slew tick, and a state sequencer chooses where the counter is heading and how fast the tick runs.

When enable rises, the sequencer waits a fixed delay. It then soft-starts at a slow rate up to a fixed boot level and holds there for a fixed time. Only after that hold does it start to follow the VID. The first ramp toward the requested level also runs at the slow rate. The soft-start-done flag rises when the counter first reaches the requested level, and from then on VID changes are tracked at the faster normal rate.

Every VID change passes through a deskew window that opens on the first changed edge. The value present when the window closes is the value taken. Off or undefined codes are ignored while a timer runs. If the timer expires, the block shuts down. A fixed offset of three steps (about −19 mV) is folded into every target before the counter compares against it.

Top module: `vid_slew_seq`

## Requirements
- R1: After reset, with enable low, `dac_level` is 0 and `ss_done` and `shutdown` are low.
- R2: After enable is sampled high, `dac_level` stays 0 for ENA_DLY cycles. The first step up follows within SS_DIV further cycles.
- R3: A code c is valid when 0x02 ≤ c ≤ 0xB2. Its target level is 255 − c, counted in 6.25 mV units above zero: 258 − c is the nominal value, and three steps of offset are removed from it.
- R4: `dac_level` changes by at most one per cycle and moves only toward its target. It stops on the target and never passes it.
- R5: Until `ss_done` rises, a step is taken every SS_DIV cycles. After that, a step is taken every TRK_DIV cycles.
- R6: Soft start ramps to the level of boot code 0x52 (173). The level stays there for at least HOLD_CYC cycles before it moves toward the requested code, either up or down.
- R7: The VID is not acted on before the boot hold ends. An invalid code held during the soft-start ramp causes no shutdown.
- R8: `ss_done` is low until `dac_level` first equals the requested target after the hold. It rises one cycle after that and stays high while enabled.
- R9: A VID change takes effect DSK_CYC cycles after the first changed edge is seen. A change that reverts within that window has no effect on `dac_level`.
- R10: While tracking, an invalid code holds `dac_level` where it is. If the invalid code stays for INV_TMO cycles, `shutdown` rises. A shorter invalid burst has no effect.
- R11: In shutdown, `dac_level` is 0. Shutdown stays latched whatever the VID does, until enable goes low.
- R12: When enable is sampled low, then on the next cycle `dac_level` is 0 and both flags are low, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High starts the sequence; low returns the block to off |
| vid | input | 8 | Requested voltage-identification code |
| dac_level | output | 8 | Reference level in 6.25 mV units, offset included |
| ss_done | output | 1 | First ramp after the boot hold has reached its target |
| shutdown | output | 1 | Latched invalid-code shutdown |

## Verification
The bench sweeps every valid code one step at a time and compares each settled level with 255 − c. It also checks that the level passes monotonically between the old and new targets. A design with the offset or the code direction wrong would settle on the wrong level, and one that overshoots would show a sample beyond the target.

The bench measures the spacing between steps during soft start, during the boot-to-final ramp and during tracking. A design that switches rates at the wrong moment would show the wrong interval. It also times the enable delay and the boot plateau, and it requires the ramp to leave the plateau in the right direction.

For the deskew window, it checks that a code which reverts within the window leaves the level untouched; a design that restarts or skips the window would move the level. It holds invalid codes during the ramp, in short bursts and for a sustained period, and checks that shutdown comes only after the time-out and is released only by enable.

// File: rtl/vslw_pkg.sv
package vslw_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ENWAIT,
        ST_SSRAMP,
        ST_HOLD,
        ST_TRACK,
        ST_SHUT
    } seq_st_e;

    // A code selects a DAC voltage only inside this window; the rest mean off
    function automatic logic code_ok(input logic [7:0] c);
        return (c >= 8'h02) && (c <= 8'hB2);
    endfunction

    // Level in 6.25 mV units: 0x02 sits 256 steps up, higher codes go lower
    function automatic logic [7:0] code_to_level(input logic [7:0] c,
                                                 input logic [7:0] ofs);
        logic [8:0] t;
        t = 9'd258 - {1'b0, c} - {1'b0, ofs};
        return t[7:0];
    endfunction

endpackage

// File: rtl/vslw_deskew.sv
module vslw_deskew #(
    parameter int DSK_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] vid_i,
    output logic [7:0] lat_o
);
    localparam int CW = $clog2(DSK_CYC + 1);

    typedef struct packed {
        logic [7:0]    lat;
        logic          busy;
        logic [CW-1:0] cnt;
    } dsk_s;

    dsk_s dsk_d, dsk_q;

    always_comb begin
        dsk_d = dsk_q;
        if (!dsk_q.busy) begin
            if (vid_i != dsk_q.lat) begin
                dsk_d.busy = 1'b1;
                dsk_d.cnt  = '0;
            end
        end else if (dsk_q.cnt == CW'(DSK_CYC - 1)) begin
            dsk_d.lat  = vid_i;
            dsk_d.busy = 1'b0;
        end else begin
            dsk_d.cnt = dsk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dsk_q <= '0;
        else        dsk_q <= dsk_d;
    end

    assign lat_o = dsk_q.lat;

    // R9
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_q.busy && dsk_q.cnt != CW'(DSK_CYC - 1)) |=> $stable(lat_o));

endmodule

// File: rtl/vslw_tick.sv
module vslw_tick #(
    parameter int SS_DIV  = 6,
    parameter int TRK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int DMAX = (SS_DIV > TRK_DIV) ? SS_DIV : TRK_DIV;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim    = slow_i ? CW'(SS_DIV - 1) : CW'(TRK_DIV - 1);
        tick_o = run_i && (cnt_q >= lim);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/vid_slew_seq.sv
module vid_slew_seq
    import vslw_pkg::*;
#(
    parameter int         ENA_DLY   = 40,
    parameter int         HOLD_CYC  = 30,
    parameter int         SS_DIV    = 6,
    parameter int         TRK_DIV   = 2,
    parameter int         DSK_CYC   = 8,
    parameter int         INV_TMO   = 50,
    parameter logic [7:0] BOOT_CODE = 8'h52,
    parameter int         OFS_STEPS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [7:0] vid,
    output logic [7:0] dac_level,
    output logic       ss_done,
    output logic       shutdown
);
    localparam int         TM1      = (ENA_DLY > HOLD_CYC) ? ENA_DLY : HOLD_CYC;
    localparam int         TMAX     = (TM1 > INV_TMO) ? TM1 : INV_TMO;
    localparam int         TW       = $clog2(TMAX + 1);
    localparam logic [7:0] OFS      = 8'(OFS_STEPS);
    localparam logic [7:0] BOOT_LVL = code_to_level(BOOT_CODE, OFS);

    typedef struct packed {
        seq_st_e       st;
        logic [7:0]    level;
        logic [7:0]    target;
        logic [TW-1:0] tmr;
        logic          ss_done;
    } seq_s;

    localparam seq_s SEQ_RST = '{st: ST_OFF, level: 8'd0, target: 8'd0,
                                 tmr: '0, ss_done: 1'b0};

    seq_s       seq_d, seq_q;
    logic [7:0] lat_code, lat_lvl, step_lvl;
    logic       lat_ok, tick, run;

    vslw_deskew #(.DSK_CYC(DSK_CYC)) u_dsk (
        .clk   (clk),
        .rst_n (rst_n),
        .vid_i (vid),
        .lat_o (lat_code)
    );

    assign run = (seq_q.st == ST_SSRAMP) || (seq_q.st == ST_TRACK);

    vslw_tick #(.SS_DIV(SS_DIV), .TRK_DIV(TRK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .slow_i (!seq_q.ss_done),
        .tick_o (tick)
    );

    always_comb begin
        seq_d    = seq_q;
        lat_ok   = code_ok(lat_code);
        lat_lvl  = code_to_level(lat_code, OFS);
        step_lvl = seq_q.level;
        if (tick) begin
            if (seq_q.level < seq_q.target)      step_lvl = seq_q.level + 8'd1;
            else if (seq_q.level > seq_q.target) step_lvl = seq_q.level - 8'd1;
        end

        unique case (seq_q.st)
            ST_OFF: begin
                seq_d.level = '0;
                if (enable) begin
                    seq_d.st  = ST_ENWAIT;
                    seq_d.tmr = '0;
                end
            end
            ST_ENWAIT: begin
                if (seq_q.tmr == TW'(ENA_DLY - 1)) begin
                    seq_d.st     = ST_SSRAMP;
                    seq_d.target = BOOT_LVL;
                    seq_d.tmr    = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_SSRAMP: begin
                if (seq_q.level == seq_q.target) begin
                    seq_d.st  = ST_HOLD;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.level = step_lvl;
                end
            end
            ST_HOLD: begin
                if (seq_q.tmr == TW'(HOLD_CYC - 1)) begin
                    seq_d.st  = ST_TRACK;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_TRACK: begin
                seq_d.level = step_lvl;
                if (lat_ok) begin
                    seq_d.target = lat_lvl;
                    seq_d.tmr    = '0;
                    if (seq_q.level == seq_q.target && seq_q.target == lat_lvl)
                        seq_d.ss_done = 1'b1;
                end else if (seq_q.tmr == TW'(INV_TMO - 1)) begin
                    seq_d.st    = ST_SHUT;
                    seq_d.level = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_SHUT: seq_d.level = '0;
            default: seq_d = SEQ_RST;
        endcase

        if (!enable) seq_d = SEQ_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign dac_level = seq_q.level;
    assign ss_done   = seq_q.ss_done;
    assign shutdown  = (seq_q.st == ST_SHUT);

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !shutdown) |->
        (({1'b0, dac_level} <= {1'b0, $past(dac_level)} + 9'd1) &&
         ({1'b0, dac_level} + 9'd1 >= {1'b0, $past(dac_level)})));

    // R4
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TRACK && seq_q.level < seq_q.target) |=>
        (seq_q.level <= $past(seq_q.target)));

    // R4
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TRACK && seq_q.level > seq_q.target) |=>
        (seq_q.st == ST_OFF || seq_q.st == ST_SHUT || seq_q.level >= $past(seq_q.target)));

    // R12
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dac_level == 8'd0 && !ss_done && !shutdown));

    // R11
    shut_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (dac_level == 8'd0));

    // R11
    shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && enable) |=> shutdown);

    // R8
    ss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && enable) |=> ss_done);

endmodule

// File: tb/tb_vid_slew_seq.sv
`timescale 1ns/1ps
module tb_vid_slew_seq;
    localparam int ENA_DLY  = 40;
    localparam int HOLD_CYC = 30;
    localparam int SS_DIV   = 6;
    localparam int TRK_DIV  = 2;
    localparam int DSK_CYC  = 8;
    localparam int INV_TMO  = 50;
    localparam int BOOT_LVL = 173;

    logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [7:0] vid = 8'h32;
    logic [7:0] dac_level;
    logic       ss_done, shutdown;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    vid_slew_seq #(.ENA_DLY(ENA_DLY), .HOLD_CYC(HOLD_CYC), .SS_DIV(SS_DIV),
                   .TRK_DIV(TRK_DIV), .DSK_CYC(DSK_CYC), .INV_TMO(INV_TMO)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .vid(vid),
        .dac_level(dac_level), .ss_done(ss_done), .shutdown(shutdown));

    function automatic int lvl_of(input int c);
        return 255 - c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_chg(input int maxc, output int k);
        logic [7:0] s0;
        s0 = dac_level;
        k = 0;
        while (dac_level == s0 && k < maxc) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_lvl(input int lv, input int maxc, output int k);
        k = 0;
        while (dac_level != lv && k < maxc) begin
            @(negedge clk);
            k++;
        end
    endtask

    // R3 R4: request code, follow level monotonically to 255-c
    task automatic track_to(input int c, input int maxc);
        int s0, tg, k;
        bit mono;
        s0 = dac_level; tg = lvl_of(c); mono = 1; k = 0;
        vid = 8'(c);
        while (dac_level != tg && k < maxc) begin
            @(negedge clk);
            k++;
            if (tg >= s0 && (dac_level < s0 || dac_level > tg)) mono = 0;
            if (tg <  s0 && (dac_level > s0 || dac_level < tg)) mono = 0;
        end
        chk(dac_level == tg, "R3 settled level", dac_level, tg);
        chk(mono, "R4 monotonic without overshoot", dac_level, tg);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int k;
        bit ok;
        cyc(3);
        chk(dac_level == 0 && !ss_done && !shutdown, "R1 in reset", dac_level, 0);
        rst_n = 1'b1;
        cyc(3);
        chk(dac_level == 0 && !ss_done && !shutdown, "R1 after reset", dac_level, 0);

        // R2 enable delay
        enable = 1'b1;
        wait_chg(ENA_DLY + SS_DIV + 20, k);
        chk(k >= ENA_DLY + 1 && k <= ENA_DLY + SS_DIV + 1, "R2 enable delay", k, ENA_DLY + SS_DIV + 1);
        chk(dac_level == 1, "R4 first step", dac_level, 1);

        // R5 soft-start spacing
        for (int i = 0; i < 6; i++) begin
            wait_chg(SS_DIV * 4, k);
            chk(k == SS_DIV, "R5 soft-start step spacing", k, SS_DIV);
        end

        // R7 invalid code before end of hold is not acted on
        vid = 8'hFF;
        cyc(INV_TMO + DSK_CYC + 20);
        chk(!shutdown, "R7 no shutdown during ramp", shutdown, 0);
        vid = 8'h32;

        // R6 boot plateau
        wait_lvl(BOOT_LVL, BOOT_LVL * SS_DIV + 50, k);
        chk(dac_level == BOOT_LVL, "R6 boot level", dac_level, BOOT_LVL);
        wait_chg(HOLD_CYC + SS_DIV * 4, k);
        chk(k >= HOLD_CYC && k <= HOLD_CYC + SS_DIV + 4, "R6 hold length", k, HOLD_CYC);
        chk(dac_level == BOOT_LVL + 1, "R6 leaves hold upward", dac_level, BOOT_LVL + 1);
        chk(!ss_done, "R8 low before target", ss_done, 0);

        // R5 ramp after hold still slow
        for (int i = 0; i < 3; i++) begin
            wait_chg(SS_DIV * 4, k);
            chk(k == SS_DIV, "R5 post-hold spacing", k, SS_DIV);
        end

        // R8 soft-start done
        wait_lvl(lvl_of(8'h32), 100 * SS_DIV, k);
        chk(dac_level == lvl_of(8'h32) && !ss_done, "R8 low on arrival", ss_done, 0);
        cyc(1);
        chk(ss_done, "R8 rises next cycle", ss_done, 1);

        // R3 R4 sweep over every valid code
        for (int c = 2; c <= 178; c++) track_to(c, 60 * TRK_DIV + DSK_CYC + 20);

        // R5 tracking spacing on large jump
        vid = 8'h02;
        wait_chg(DSK_CYC + 20, k);
        for (int i = 0; i < 5; i++) begin
            wait_chg(TRK_DIV * 4, k);
            chk(k == TRK_DIV, "R5 tracking step spacing", k, TRK_DIV);
        end
        wait_lvl(lvl_of(8'h02), 200 * TRK_DIV, k);
        chk(dac_level == lvl_of(8'h02), "R3 code 0x02 level", dac_level, lvl_of(8'h02));
        chk(ss_done, "R8 stays high", ss_done, 1);

        // R9 deskew latency
        vid = 8'h10;
        ok = 1;
        for (int i = 0; i < DSK_CYC; i++) begin
            @(negedge clk);
            if (dac_level != lvl_of(8'h02)) ok = 0;
        end
        chk(ok, "R9 no move inside window", dac_level, lvl_of(8'h02));
        track_to(8'h10, 40 * TRK_DIV + DSK_CYC);

        // R9 reverting glitch
        vid = 8'h20;
        cyc(3);
        vid = 8'h10;
        ok = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dac_level != lvl_of(8'h10)) ok = 0;
        end
        chk(ok, "R9 glitch ignored", dac_level, lvl_of(8'h10));

        // R10 short invalid burst
        vid = 8'h00;
        ok = 1;
        for (int i = 0; i < INV_TMO / 2; i++) begin
            @(negedge clk);
            if (dac_level != lvl_of(8'h10) || shutdown) ok = 0;
        end
        vid = 8'h10;
        for (int i = 0; i < INV_TMO * 2; i++) begin
            @(negedge clk);
            if (dac_level != lvl_of(8'h10) || shutdown) ok = 0;
        end
        chk(ok, "R10 short burst held level", dac_level, lvl_of(8'h10));

        // R10 sustained invalid
        vid = 8'hC0;
        k = 0;
        while (!shutdown && k < INV_TMO + DSK_CYC + 30) begin
            @(negedge clk);
            k++;
        end
        chk(k >= INV_TMO + DSK_CYC - 1 && k <= INV_TMO + DSK_CYC + 3, "R10 time-out", k, INV_TMO + DSK_CYC + 1);
        chk(dac_level == 0, "R11 level zero", dac_level, 0);
        vid = 8'h10;
        cyc(100);
        chk(shutdown && dac_level == 0, "R11 stays latched", shutdown, 1);

        // R12 disable clears
        enable = 1'b0;
        cyc(1);
        chk(dac_level == 0 && !shutdown && !ss_done, "R12 clear from shutdown", shutdown, 0);

        // R6 restart to a code below boot, then R12 from running
        vid = 8'hB2;
        cyc(2);
        enable = 1'b1;
        wait_lvl(BOOT_LVL, ENA_DLY + BOOT_LVL * SS_DIV + 50, k);
        wait_chg(HOLD_CYC + SS_DIV * 4, k);
        chk(dac_level == BOOT_LVL - 1, "R6 leaves hold downward", dac_level, BOOT_LVL - 1);
        wait_lvl(lvl_of(8'hB2), 120 * SS_DIV, k);
        chk(dac_level == lvl_of(8'hB2), "R3 code 0xB2 level", dac_level, lvl_of(8'hB2));
        cyc(2);
        chk(ss_done, "R8 set after restart", ss_done, 1);
        enable = 1'b0;
        cyc(1);
        chk(dac_level == 0 && !ss_done && !shutdown, "R12 clear from tracking", dac_level, 0);

        finish_run();
    end
endmodule